// File: doc/BRIEF.md
# Multi-Channel Memory Request Arbiter

This block connects a set of independent requesting units, such as per-thread load/store units or per-core instruction fetchers, to an external memory that offers a small fixed number of access channels. Every requester raises a read or write request with an address and, for a write, a data word. The block forwards at most one request per free channel and holds the rest until a channel frees. When memory answers, the response goes back to the requester that issued the request.

Each channel remembers the requester it serves. It keeps its memory request steady until memory answers, relays the answer to that requester for one cycle, and becomes free only once the requester has dropped its request. Idle channels take pending requests in fixed priority order, lowest requester index first. Channel 0 chooses before channel 1, and a requester already chosen or already being served is never taken again.

A parameter selects the variant. The data-memory variant uses an 8-bit address and 8-bit words and supports reads and writes. The program-memory variant uses an 8-bit address and 16-bit words and accepts reads only.

Top module: `mem_channel_arbiter`

## Requirements
- R1: While reset is asserted, and after its release until a request arrives, every `req_ready`, `mem_rd_valid` and `mem_wr_valid` bit is 0.
- R2: A request taken by a free channel appears on that channel one clock edge after the request was first sampled. It appears as `mem_rd_valid` (read) or `mem_wr_valid` (write) together with the requester's address in bits `[c*8 +: 8]` of `mem_addr`. Valid, address and write data stay unchanged until `mem_ready` for that channel is sampled high.
- R3: No requester is served by more than one channel at a time. Up to `NUM_CH` requests are outstanding toward memory at once.
- R4: A memory response is returned only to the requester that issued the request. `req_ready[i]` is high for exactly one cycle, one edge after `mem_ready`, and carries the memory word in bits `[i*DW +: DW]` of `req_rdata` for a read.
- R5: Idle channels take pending requesters lowest index first. Channel 0 takes the lowest pending index and channel 1 the next, and no requester is granted to two channels in one cycle.
- R6: In the data variant, a write request drives `mem_wr_valid` with its address and its 8-bit word from `req_wdata[i*8 +: 8]`, and completes with a one-cycle `req_ready`. A later read of that address returns the written word.
- R7: In the program variant (`WRITABLE`=0, 16-bit words), `req_wr_valid` is ignored. No memory access is issued, `mem_wr_valid` stays 0 and no `req_ready` is returned for a write-only request. Reads return 16-bit words.
- R8: A requester that keeps its request high after its `req_ready` pulse is not served again. Its channel issues nothing to memory until the request is dropped, and a request raised afterwards is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_rd_valid | input | NUM_REQ | Read request per requester |
| req_wr_valid | input | NUM_REQ | Write request per requester (ignored when WRITABLE=0) |
| req_addr | input | NUM_REQ*8 | Request address, 8 bits per requester |
| req_wdata | input | NUM_REQ*DW | Write word per requester |
| req_ready | output | NUM_REQ | One-cycle completion per requester |
| req_rdata | output | NUM_REQ*DW | Read word per requester, valid with req_ready |
| mem_rd_valid | output | NUM_CH | Read access per channel |
| mem_wr_valid | output | NUM_CH | Write access per channel |
| mem_addr | output | NUM_CH*8 | Address per channel |
| mem_wdata | output | NUM_CH*DW | Write word per channel |
| mem_ready | input | NUM_CH | Memory completion per channel |
| mem_rdata | input | NUM_CH*DW | Read word per channel, valid with mem_ready |

## Verification
The bench builds two instances. The first is a writable 8-bit variant with four requesters on two channels, so requesters outnumber channels. That reaches queueing, the second-channel priority pick and response routing while both channels are busy. The second is a read-only 16-bit variant with three requesters on one channel. It exercises the ignored write path and the wider word. Memory latency is fixed for the cycle-exact checks and random for the concurrent streams, so responses come back out of issue order.

// File: rtl/mca_pkg.sv
package mca_pkg;
  typedef enum logic [1:0] {
    CH_IDLE     = 2'd0,
    CH_WAIT_MEM = 2'd1,
    CH_RELAY    = 2'd2,
    CH_RELEASE  = 2'd3
  } ch_state_e;
endpackage

// File: rtl/mca_lowest_pick.sv
module mca_lowest_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  cand,
  output logic [N-1:0]  pick_oh,
  output logic [IW-1:0] pick_idx,
  output logic          pick_any
);
  // Scan from the top so the lowest candidate is the last one written.
  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    pick_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick_oh    = '0;
        pick_oh[i] = 1'b1;
        pick_idx   = IW'(i);
        pick_any   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mca_channel.sv
module mca_channel import mca_pkg::*; #(
  parameter int NUM_REQ = 4,
  parameter int IW      = 2,
  parameter int AW      = 8,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [IW-1:0]      start_idx_i,
  input  logic [AW-1:0]      start_addr_i,
  input  logic [DW-1:0]      start_wdata_i,
  input  logic               start_wr_i,
  input  logic [NUM_REQ-1:0] req_active_i,
  output logic               idle_o,
  output logic [IW-1:0]      owner_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic               mem_ready_i,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic               relay_o,
  output logic [DW-1:0]      relay_data_o
);
  ch_state_e       state_q, state_d;
  logic [IW-1:0]   owner_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic            wr_q;
  logic [DW-1:0]   data_q;
  logic            owner_active;
  logic            load_req;
  logic            load_rsp;

  assign owner_active = req_active_i[owner_q];
  assign load_req     = (state_q == CH_IDLE) && start_i;
  assign load_rsp     = (state_q == CH_WAIT_MEM) && mem_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CH_IDLE:     if (start_i)      state_d = CH_WAIT_MEM;
      CH_WAIT_MEM: if (mem_ready_i)  state_d = CH_RELAY;
      CH_RELAY:    state_d = owner_active ? CH_RELEASE : CH_IDLE;
      CH_RELEASE:  if (!owner_active) state_d = CH_IDLE;
      default:     state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CH_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (load_req) begin
      owner_q <= start_idx_i;
      addr_q  <= start_addr_i;
      wdata_q <= start_wdata_i;
      wr_q    <= start_wr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (load_rsp) data_q <= mem_rdata_i;
  end

  assign idle_o       = (state_q == CH_IDLE);
  assign owner_o      = owner_q;
  assign mem_rd_o     = (state_q == CH_WAIT_MEM) && !wr_q;
  assign mem_wr_o     = (state_q == CH_WAIT_MEM) && wr_q;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = wdata_q;
  assign relay_o      = (state_q == CH_RELAY);
  assign relay_data_o = data_q;

  // R2: an access held toward memory does not change until memory answers
  assert_hold_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd_o || mem_wr_o) && !mem_ready_i) |=>
      ((mem_rd_o || mem_wr_o) && $stable(mem_addr_o) && $stable(mem_wr_o) && $stable(mem_wdata_o)));

  // R4: the completion toward a requester lasts one cycle
  assert_relay_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    relay_o |=> !relay_o);

  // R4: a completion only goes to a requester that was still asking
  assert_owner_asking_R4: assert property (@(posedge clk) disable iff (!rst_n)
    relay_o |-> $past(owner_active));

  // R8: a requester holding on after completion gets no second access
  assert_no_reissue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_RELEASE && owner_active) |=> (!relay_o && !mem_rd_o && !mem_wr_o));
endmodule

// File: rtl/mem_channel_arbiter.sv
module mem_channel_arbiter #(
  parameter int NUM_REQ  = 4,
  parameter int NUM_CH   = 2,
  parameter bit WRITABLE = 1'b1,
  parameter int AW       = 8,
  localparam int DW      = WRITABLE ? 8 : 16,
  localparam int IW      = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_REQ-1:0]    req_rd_valid,
  input  logic [NUM_REQ-1:0]    req_wr_valid,
  input  logic [NUM_REQ*AW-1:0] req_addr,
  input  logic [NUM_REQ*DW-1:0] req_wdata,
  output logic [NUM_REQ-1:0]    req_ready,
  output logic [NUM_REQ*DW-1:0] req_rdata,
  output logic [NUM_CH-1:0]     mem_rd_valid,
  output logic [NUM_CH-1:0]     mem_wr_valid,
  output logic [NUM_CH*AW-1:0]  mem_addr,
  output logic [NUM_CH*DW-1:0]  mem_wdata,
  input  logic [NUM_CH-1:0]     mem_ready,
  input  logic [NUM_CH*DW-1:0]  mem_rdata
);
  logic [NUM_REQ-1:0] wr_req;
  logic [NUM_REQ-1:0] active;
  logic [NUM_REQ-1:0] served;
  logic [NUM_REQ-1:0] pending;
  logic [NUM_CH-1:0]  serve_mat [NUM_REQ];
  logic [NUM_CH-1:0]  grant_mat [NUM_REQ];

  logic [NUM_REQ-1:0] cand     [NUM_CH+1];
  logic [NUM_REQ-1:0] pick_oh  [NUM_CH];
  logic [IW-1:0]      pick_idx [NUM_CH];
  logic [NUM_CH-1:0]  pick_any;
  logic [NUM_CH-1:0]  ch_start;
  logic [NUM_CH-1:0]  ch_idle;
  logic [IW-1:0]      ch_owner [NUM_CH];
  logic [NUM_CH-1:0]  ch_relay;
  logic [DW-1:0]      ch_data  [NUM_CH];

  // Variant select: the read-only variant never sees a write.
  generate
    if (WRITABLE) begin : g_rw
      assign wr_req = req_wr_valid;
    end else begin : g_ro
      assign wr_req = '0;
    end
  endgenerate

  assign active = req_rd_valid | wr_req;

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        serve_mat[i][c] = !ch_idle[c] && (ch_owner[c] == IW'(i));
        grant_mat[i][c] = ch_start[c] && pick_oh[c][i];
      end
      served[i] = |serve_mat[i];
    end
  end

  assign pending = active & ~served;
  assign cand[0] = pending;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      mca_lowest_pick #(.N(NUM_REQ), .IW(IW)) i_pick (
        .cand     (cand[c]),
        .pick_oh  (pick_oh[c]),
        .pick_idx (pick_idx[c]),
        .pick_any (pick_any[c])
      );

      assign ch_start[c] = ch_idle[c] && pick_any[c];
      // A requester granted here is hidden from higher channels this cycle.
      assign cand[c+1]   = ch_start[c] ? (cand[c] & ~pick_oh[c]) : cand[c];

      mca_channel #(.NUM_REQ(NUM_REQ), .IW(IW), .AW(AW), .DW(DW)) i_channel (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (ch_start[c]),
        .start_idx_i   (pick_idx[c]),
        .start_addr_i  (req_addr[pick_idx[c]*AW +: AW]),
        .start_wdata_i (req_wdata[pick_idx[c]*DW +: DW]),
        .start_wr_i    (wr_req[pick_idx[c]]),
        .req_active_i  (active),
        .idle_o        (ch_idle[c]),
        .owner_o       (ch_owner[c]),
        .mem_rd_o      (mem_rd_valid[c]),
        .mem_wr_o      (mem_wr_valid[c]),
        .mem_addr_o    (mem_addr[c*AW +: AW]),
        .mem_wdata_o   (mem_wdata[c*DW +: DW]),
        .mem_ready_i   (mem_ready[c]),
        .mem_rdata_i   (mem_rdata[c*DW +: DW]),
        .relay_o       (ch_relay[c]),
        .relay_data_o  (ch_data[c])
      );
    end
  endgenerate

  // Route each completion back to the requester its channel remembers.
  always_comb begin
    req_ready = '0;
    req_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_relay[c]) begin
        req_ready[ch_owner[c]]              = 1'b1;
        req_rdata[ch_owner[c]*DW +: DW]     = ch_data[c];
      end
    end
  end

  generate
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_chk
      // R3: at most one channel holds a given requester
      assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(serve_mat[i]) <= 1);
      // R5: one grant per requester per cycle, and never to one already served
      assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_mat[i]) && !(served[i] && (|grant_mat[i])));
    end
  endgenerate
endmodule

// File: tb/test_mem_channel_arbiter.sv
module tb_memory #(
  parameter int NCH = 2,
  parameter int DW  = 8,
  parameter bit WR  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  int                lat,
  input  logic [NCH-1:0]    rd,
  input  logic [NCH-1:0]    wr,
  input  logic [NCH*8-1:0]  addr,
  input  logic [NCH*DW-1:0] wdata,
  output logic [NCH-1:0]    ready,
  output logic [NCH*DW-1:0] rdata
);
  logic [DW-1:0] mem [256];
  logic [NCH-1:0] busy;
  int cnt [NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= '0;
      rdata <= '0;
      busy  <= '0;
      for (int c = 0; c < NCH; c++) cnt[c] <= 0;
      for (int a = 0; a < 256; a++)
        mem[a] <= (DW > 8) ? DW'((((a ^ 'h5A) & 255) << 8) | a) : DW'((a * 5 + 17) & 255);
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (ready[c]) begin
          ready[c] <= 1'b0;
          busy[c]  <= 1'b0;
        end else if (rd[c] || wr[c]) begin
          if (!busy[c]) begin
            busy[c] <= 1'b1;
            cnt[c]  <= (lat > 0) ? lat - 1 : int'($urandom_range(3, 0));
          end else if (cnt[c] == 0) begin
            ready[c] <= 1'b1;
            rdata[c*DW +: DW] <= mem[addr[c*8 +: 8]];
            if (WR && wr[c]) mem[addr[c*8 +: 8]] <= wdata[c*DW +: DW];
          end else begin
            cnt[c] <= cnt[c] - 1;
          end
        end
      end
    end
  end
endmodule

module test_mem_channel_arbiter;
  logic clk;
  logic rst_n;
  int   lat;
  int   checks;
  int   errors;
  bit   done;

  // Writable instance: 4 requesters, 2 channels, 8-bit words
  logic [3:0]  d_rd, d_wr, d_ready;
  logic [31:0] d_addr, d_wdata, d_rdata;
  logic [1:0]  d_mrd, d_mwr, d_mready;
  logic [15:0] d_maddr, d_mwdata, d_mrdata;

  // Read-only instance: 3 requesters, 1 channel, 16-bit words
  logic [2:0]  p_rd, p_wr, p_ready;
  logic [23:0] p_addr;
  logic [47:0] p_wdata, p_rdata;
  logic [0:0]  p_mrd, p_mwr, p_mready;
  logic [7:0]  p_maddr;
  logic [15:0] p_mwdata, p_mrdata;

  mem_channel_arbiter #(.NUM_REQ(4), .NUM_CH(2), .WRITABLE(1'b1)) i_mem_channel_arbiter (
    .clk(clk), .rst_n(rst_n),
    .req_rd_valid(d_rd), .req_wr_valid(d_wr), .req_addr(d_addr), .req_wdata(d_wdata),
    .req_ready(d_ready), .req_rdata(d_rdata),
    .mem_rd_valid(d_mrd), .mem_wr_valid(d_mwr), .mem_addr(d_maddr), .mem_wdata(d_mwdata),
    .mem_ready(d_mready), .mem_rdata(d_mrdata)
  );

  tb_memory #(.NCH(2), .DW(8), .WR(1'b1)) i_dmem (
    .clk(clk), .rst_n(rst_n), .lat(lat), .rd(d_mrd), .wr(d_mwr), .addr(d_maddr),
    .wdata(d_mwdata), .ready(d_mready), .rdata(d_mrdata)
  );

  mem_channel_arbiter #(.NUM_REQ(3), .NUM_CH(1), .WRITABLE(1'b0)) i_mem_channel_arbiter_ro (
    .clk(clk), .rst_n(rst_n),
    .req_rd_valid(p_rd), .req_wr_valid(p_wr), .req_addr(p_addr), .req_wdata(p_wdata),
    .req_ready(p_ready), .req_rdata(p_rdata),
    .mem_rd_valid(p_mrd), .mem_wr_valid(p_mwr), .mem_addr(p_maddr), .mem_wdata(p_mwdata),
    .mem_ready(p_mready), .mem_rdata(p_mrdata)
  );

  tb_memory #(.NCH(1), .DW(16), .WR(1'b0)) i_pmem (
    .clk(clk), .rst_n(rst_n), .lat(lat), .rd(p_mrd), .wr(p_mwr), .addr(p_maddr),
    .wdata(p_mwdata), .ready(p_mready), .rdata(p_mrdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] dexp(int a);
    return 8'((a * 5 + 17) & 255);
  endfunction

  function automatic logic [15:0] pexp(int a);
    return {8'(a) ^ 8'h5A, 8'(a)};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Wait for completion of an already raised request, then release it.
  task automatic finish_req(int r, bit chk, int exp, string tag);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!d_ready[r] && n < 500);
    check(d_ready[r] == 1'b1, tag, $sformatf("completion for requester %0d", r), d_ready[r], 1);
    if (chk)
      check(d_rdata[r*8 +: 8] == 8'(exp), tag, $sformatf("data to requester %0d", r),
            d_rdata[r*8 +: 8], exp);
    d_rd[r] = 1'b0;
    d_wr[r] = 1'b0;
    @(negedge clk);
    check(d_ready[r] == 1'b0, "R4", "completion lasts one cycle", d_ready[r], 0);
  endtask

  task automatic do_req(int r, bit wr, int addr, int wd, bit chk, int exp, string tag);
    @(negedge clk);
    d_addr[r*8 +: 8]  = 8'(addr);
    d_wdata[r*8 +: 8] = 8'(wd);
    if (wr) d_wr[r] = 1'b1;
    else    d_rd[r] = 1'b1;
    finish_req(r, chk, exp, tag);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    check(d_ready == 0 && d_mrd == 0 && d_mwr == 0, "R1", "outputs in reset",
          {d_ready, d_mrd, d_mwr}, 0);
    check(p_ready == 0 && p_mrd == 0 && p_mwr == 0, "R1", "read-only outputs in reset",
          {p_ready, p_mrd, p_mwr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(d_ready == 0 && d_mrd == 0 && d_mwr == 0, "R1", "outputs after reset",
          {d_ready, d_mrd, d_mwr}, 0);
  endtask

  task automatic t_single_read();
    lat = 4;
    @(negedge clk);
    d_addr[2*8 +: 8] = 8'h15;
    d_rd[2] = 1'b1;
    @(negedge clk);
    check(d_mrd == 2'b01 && d_mwr == 2'b00, "R2", "read forwarded on channel 0", d_mrd, 1);
    check(d_maddr[7:0] == 8'h15, "R2", "channel 0 address", d_maddr[7:0], 'h15);
    @(negedge clk);
    check(d_mrd[0] == 1'b1 && d_maddr[7:0] == 8'h15, "R2", "request held until answer",
          d_mrd[0], 1);
    finish_req(2, 1'b1, dexp('h15), "R4");
  endtask

  task automatic t_priority();
    lat = 6;
    @(negedge clk);
    for (int r = 0; r < 4; r++) begin
      d_addr[r*8 +: 8] = 8'(8'h30 + r);
      d_rd[r] = 1'b1;
    end
    @(negedge clk);
    check(d_mrd == 2'b11, "R5", "both channels taken", d_mrd, 3);
    check(d_maddr[7:0] == 8'h30, "R5", "channel 0 takes requester 0", d_maddr[7:0], 'h30);
    check(d_maddr[15:8] == 8'h31, "R5", "channel 1 takes requester 1", d_maddr[15:8], 'h31);
    fork
      finish_req(0, 1'b1, dexp('h30), "R4");
      finish_req(1, 1'b1, dexp('h31), "R4");
      finish_req(2, 1'b1, dexp('h32), "R3");
      finish_req(3, 1'b1, dexp('h33), "R3");
    join
  endtask

  task automatic t_write();
    lat = 3;
    @(negedge clk);
    d_addr[1*8 +: 8]  = 8'hF0;
    d_wdata[1*8 +: 8] = 8'hA5;
    d_wr[1] = 1'b1;
    @(negedge clk);
    check(d_mwr == 2'b01 && d_mrd == 2'b00, "R6", "write forwarded on channel 0", d_mwr, 1);
    check(d_maddr[7:0] == 8'hF0 && d_mwdata[7:0] == 8'hA5, "R6", "write address and word",
          {d_maddr[7:0], d_mwdata[7:0]}, 'hF0A5);
    finish_req(1, 1'b0, 0, "R6");
    do_req(3, 1'b0, 'hF0, 0, 1'b1, 'hA5, "R6");
  endtask

  task automatic t_hold();
    bit quiet = 1'b1;
    int n = 0;
    lat = 2;
    @(negedge clk);
    d_addr[7:0] = 8'h07;
    d_rd[0] = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!d_ready[0] && n < 500);
    check(d_ready[0] && d_rdata[7:0] == dexp('h07), "R4", "data before hold",
          d_rdata[7:0], dexp('h07));
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (d_ready[0] || d_mrd != 0 || d_mwr != 0) quiet = 1'b0;
    end
    check(quiet, "R8", "held request not served again", quiet, 1);
    d_rd[0] = 1'b0;
    @(negedge clk);
    do_req(0, 1'b0, 'h08, 0, 1'b1, dexp('h08), "R8");
  endtask

  task automatic run_stream(int r);
    for (int k = 0; k < 8; k++)
      do_req(r, 1'b0, r * 16 + k * 3, 0, 1'b1, dexp(r * 16 + k * 3), "R4");
  endtask

  int maxpar;
  always @(negedge clk) if (rst_n && ($countones(d_mrd | d_mwr) > maxpar))
    maxpar = $countones(d_mrd | d_mwr);

  task automatic t_streams();
    lat = 0;
    maxpar = 0;
    for (int r = 0; r < 4; r++) begin
      automatic int rr = r;
      fork
        run_stream(rr);
      join_none
    end
    wait fork;
    check(maxpar == 2, "R3", "channels used in parallel", maxpar, 2);
  endtask

  task automatic t_read_only();
    bit quiet = 1'b1;
    int n = 0;
    lat = 2;
    @(negedge clk);
    p_addr[1*8 +: 8] = 8'h22;
    p_wr[1] = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (p_mwr != 0 || p_mrd != 0 || p_ready != 0) quiet = 1'b0;
    end
    check(quiet, "R7", "write request ignored", quiet, 1);
    p_wr[1] = 1'b0;
    @(negedge clk);
    p_addr[2*8 +: 8] = 8'h33;
    p_rd[2] = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!p_ready[2] && n < 500);
    check(p_ready[2] && p_rdata[32 +: 16] == pexp('h33), "R7", "16-bit read word",
          p_rdata[32 +: 16], pexp('h33));
    p_rd[2] = 1'b0;
    @(negedge clk);
    check(p_ready == 3'b000, "R7", "no stray completion", p_ready, 0);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    lat = 2;
    d_rd = '0; d_wr = '0; d_addr = '0; d_wdata = '0;
    p_rd = '0; p_wr = '0; p_addr = '0; p_wdata = '0;
    t_reset();
    t_single_read();
    t_priority();
    t_write();
    t_hold();
    t_streams();
    t_read_only();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      report();
    end
  end
endmodule